// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves fixed 8-bit characters in step with a shared serial clock. A transmit path and a receive path each have a holding register in front of a shift register. Software can therefore load the next byte, or collect the last one, while a character is still on the wire, and characters can follow each other with no idle bit time between them.

The serial clock has two possible sources. In internal mode the block makes the clock from a bit-rate enable pulse supplied by an external rate generator and drives it on the clock pin. In external mode the pin is an input, and its edges are brought into the system clock domain through a synchroniser. Outgoing data changes after a falling clock edge, incoming data is sampled on a rising edge, and bits travel least significant first. The CPU side is a set of strobes and flags: a write strobe for the transmit holding register, a transmit-empty flag, a receive-full flag, an overrun flag, one clear strobe for each of the two receive flags, and level enables for each direction.

Top module: `sync_serial_port`

## Requirements
- R1: A character is 8 data bits, LSB first. The data line changes only while the internal clock is low (one cycle after a falling edge). Each bit is valid at the following rising edge.
- R2: In internal mode `sck_oe` is 1. Exactly 8 low-then-high clock pulses are produced per character, and `sck_o` rests at 1 whenever no character is in flight or both enables are 0.
- R3: `sd_o` is 1 after reset and keeps the level of the last bit sent (the MSB) until the next character begins.
- R4: A byte written while the previous one is shifting is sent directly after it. With `bit_tick` every 4 cycles, the first falling edge of the first character and the 16th rising edge are 124 cycles apart.
- R5: `tx_empty` is 1 after reset and rises when the holding register moves into the shifter. A write with `tx_en`=1 clears it. A write with `tx_en`=0 leaves it at 1 and starts no clock pulses.
- R6: Dropping `tx_en` forces `tx_empty` to 1 on the next cycle and abandons the character being shifted. When `tx_en` is raised again, nothing is sent until a new byte is written, and that byte goes out complete.
- R7: After the 8th rising edge with `rx_en`=1, the assembled byte appears on `rd_data` and `rx_full` rises. `rx_full` falls only on a `rdrf_clr` pulse, and `rx_overrun` falls only on an `orer_clr` pulse.
- R8: When a character completes while `rx_full` is 1, `rx_overrun` is set and `rd_data` keeps the earlier byte. With the internal clock in receive-only mode, pulses continue after the overrun.
- R9: Dropping `rx_en` leaves `rx_full`, `rx_overrun` and `rd_data` unchanged. With `tx_en` also 0, the internal clock stops high.
- R10: With `ext_clk_sel`=1, `sck_oe` is 0 and `sck_o` stays 1. Shifting follows the edges of `sck_i`, which must run at no more than a quarter of the system clock rate.
- R11: In internal mode with `tx_en`=1, pulses run only while a transmit byte is in flight. With `tx_en`=0 and `rx_en`=1, characters are clocked back to back for as long as `rx_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | Half-bit enable pulse from the rate generator (at most one every 4 cycles) |
| ext_clk_sel | input | 1 | 1 selects the external clock on `sck_i` |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wr_stb | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rdrf_clr | input | 1 | Clears the receive-full flag |
| orer_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Receive holding register |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| rx_overrun | output | 1 | A character was lost because the holding register was full |
| sck_i | input | 1 | Serial clock input (external mode) |
| sck_o | output | 1 | Serial clock output (internal mode) |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |

## Verification
The case hardest to reach from the ports is an overrun under the internal clock. It needs the receive-only mode, where pulses never pause, and the bench must drive `sd_i` bit by bit in step with falling edges it counts itself while leaving `rx_full` uncleared across two characters. The back-to-back case is reached by writing the second byte inside the same cycle loop that times the clock, as soon as `tx_empty` rises. This places the write before the first character ends.

// File: rtl/ssp_pkg.sv
// Shared definitions for the synchronous serial port.
// Assumes: nothing beyond the parameter defaults below.
package ssp_pkg;
    localparam int SSP_CHAR_BITS = 8;
    localparam int SSP_SYNC_STAGES = 2;

    // Phase of the internally generated serial clock
    typedef enum logic [1:0] {
        SCLK_IDLE = 2'd0,
        SCLK_LOW  = 2'd1,
        SCLK_HIGH = 2'd2
    } sclk_state_t;
endpackage

// File: rtl/ssp_sclk_gen.sv
// Serial clock source. In internal mode it toggles the clock on each
// bit_tick while a character is requested, giving CHAR_BITS pulses per
// character and resting high. In external mode it synchronises sck_in and
// reports its edges. Either way, fall_ev / rise_ev are one-cycle pulses.
// Assumes: bit_tick at most once every 4 cycles; sck_in at or below clk/4.
module ssp_sclk_gen
    import ssp_pkg::*;
#(
    parameter int CHAR_BITS   = SSP_CHAR_BITS,
    parameter int SYNC_STAGES = SSP_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic enable,
    input  logic run_req,
    input  logic bit_tick,
    input  logic sck_in,
    output logic sck_int,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int CNT_W = $clog2(CHAR_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_BITS);

    sclk_state_t      st_q;
    logic [CNT_W-1:0] pulses_q;
    logic             sck_q, fall_q, rise_q;
    logic [SYNC_STAGES:0] sync_q;
    logic             ext_fall, ext_rise;

    // Internal clock phase machine, advanced by the rate tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SCLK_IDLE;
            pulses_q <= '0;
            sck_q    <= 1'b1;
            fall_q   <= 1'b0;
            rise_q   <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            rise_q <= 1'b0;
            if (ext_sel || !enable) begin
                st_q     <= SCLK_IDLE;
                pulses_q <= '0;
                sck_q    <= 1'b1;
            end else if (bit_tick) begin
                case (st_q)
                    SCLK_LOW: begin
                        st_q     <= SCLK_HIGH;
                        sck_q    <= 1'b1;
                        rise_q   <= 1'b1;
                        pulses_q <= pulses_q + 1'b1;
                    end
                    SCLK_HIGH: begin
                        if (pulses_q != LAST) begin
                            st_q   <= SCLK_LOW;
                            sck_q  <= 1'b0;
                            fall_q <= 1'b1;
                        end else if (run_req) begin
                            pulses_q <= '0;
                            st_q     <= SCLK_LOW;
                            sck_q    <= 1'b0;
                            fall_q   <= 1'b1;
                        end else begin
                            pulses_q <= '0;
                            st_q     <= SCLK_IDLE;
                        end
                    end
                    default: begin
                        if (run_req) begin
                            st_q   <= SCLK_LOW;
                            sck_q  <= 1'b0;
                            fall_q <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // Synchroniser chain for the external clock, one extra stage for edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
        end
    end

    assign ext_fall = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];
    assign ext_rise = ~sync_q[SYNC_STAGES] & sync_q[SYNC_STAGES-1];

    assign sck_int = sck_q;
    assign fall_ev = ext_sel ? ext_fall : fall_q;
    assign rise_ev = ext_sel ? ext_rise : rise_q;
endmodule

// File: rtl/ssp_tx.sv
// Transmit path: holding register plus shifter. A held byte moves into the
// shifter whenever the shifter is free and the path is enabled. Each falling
// event drives the next bit, LSB first, and the line keeps the last bit.
// Assumes: fall_ev/rise_ev are single-cycle pulses at least 2 cycles apart.
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int CHAR_BITS = SSP_CHAR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 wr_stb,
    input  logic [CHAR_BITS-1:0] wr_data,
    input  logic                 fall_ev,
    input  logic                 rise_ev,
    output logic                 sd_out,
    output logic                 hold_empty,
    output logic                 busy
);
    localparam int CNT_W = $clog2(CHAR_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_BITS);

    logic [CHAR_BITS-1:0] hold_q, shift_q;
    logic [CNT_W-1:0]     sent_q;
    logic                 empty_q, busy_q, sd_q;

    // Holding register, shifter and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            sent_q  <= '0;
            empty_q <= 1'b1;
            busy_q  <= 1'b0;
            sd_q    <= 1'b1;
        end else if (!tx_en) begin
            empty_q <= 1'b1;
            busy_q  <= 1'b0;
            sent_q  <= '0;
            if (wr_stb) hold_q <= wr_data;
        end else begin
            if (!busy_q) begin
                if (!empty_q) begin
                    shift_q <= hold_q;
                    empty_q <= 1'b1;
                    busy_q  <= 1'b1;
                    sent_q  <= '0;
                end
            end else begin
                if (fall_ev && sent_q != LAST) begin
                    sd_q    <= shift_q[0];
                    shift_q <= shift_q >> 1;
                    sent_q  <= sent_q + 1'b1;
                end
                if (rise_ev && sent_q == LAST) busy_q <= 1'b0;
            end
            if (wr_stb) begin
                hold_q  <= wr_data;
                empty_q <= 1'b0;
            end
        end
    end

    assign sd_out     = sd_q;
    assign hold_empty = empty_q;
    assign busy       = busy_q;
endmodule

// File: rtl/ssp_rx.sv
// Receive path: shifter plus holding register. Each rising event samples
// the line, LSB first. When a character completes, it goes to the holding
// register if that is free; otherwise the overrun flag is set and the
// stored byte is kept. The flags clear only on their own strobes.
// Assumes: sd_in is stable around the rising event.
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int CHAR_BITS = SSP_CHAR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 sd_in,
    input  logic                 rise_ev,
    input  logic                 full_clr,
    input  logic                 ovr_clr,
    output logic [CHAR_BITS-1:0] hold_data,
    output logic                 full,
    output logic                 overrun
);
    localparam int CNT_W = $clog2(CHAR_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_BITS - 1);

    logic [CHAR_BITS-1:0] shift_q, hold_q;
    logic [CNT_W-1:0]     got_q;
    logic                 full_q, ovr_q;
    logic [CHAR_BITS-1:0] next_shift;

    assign next_shift = {sd_in, shift_q[CHAR_BITS-1:1]};

    // Shifter, bit counter, holding register and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            hold_q  <= '0;
            got_q   <= '0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (full_clr) full_q <= 1'b0;
            if (ovr_clr)  ovr_q  <= 1'b0;
            if (!rx_en) begin
                got_q <= '0;
            end else if (rise_ev) begin
                shift_q <= next_shift;
                if (got_q == LAST) begin
                    got_q <= '0;
                    if (full_q) begin
                        ovr_q <= 1'b1;
                    end else begin
                        hold_q <= next_shift;
                        full_q <= 1'b1;
                    end
                end else begin
                    got_q <= got_q + 1'b1;
                end
            end
        end
    end

    assign hold_data = hold_q;
    assign full      = full_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/sync_serial_port.sv
// Full-duplex clocked serial port with double-buffered transmit and
// receive paths sharing one serial clock. It decides when the internal
// clock runs: while a transmit byte is in flight if transmit is enabled,
// otherwise continuously while receive is enabled.
// Assumes: mode and enables change only while no character is in flight,
// except for the deliberate abort by dropping tx_en.
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int CHAR_BITS   = SSP_CHAR_BITS,
    parameter int SYNC_STAGES = SSP_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 ext_clk_sel,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 wr_stb,
    input  logic [CHAR_BITS-1:0] wr_data,
    input  logic                 rdrf_clr,
    input  logic                 orer_clr,
    output logic [CHAR_BITS-1:0] rd_data,
    output logic                 tx_empty,
    output logic                 rx_full,
    output logic                 rx_overrun,
    input  logic                 sck_i,
    output logic                 sck_o,
    output logic                 sck_oe,
    input  logic                 sd_i,
    output logic                 sd_o
);
    logic fall_ev, rise_ev, sck_int, tx_busy, run_req, any_en;

    // Clock request policy: transmit-driven, else receive-only free run
    assign run_req = tx_en ? tx_busy : rx_en;
    assign any_en  = tx_en | rx_en;

    ssp_sclk_gen #(
        .CHAR_BITS  (CHAR_BITS),
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_clk_sel),
        .enable  (any_en),
        .run_req (run_req),
        .bit_tick(bit_tick),
        .sck_in  (sck_i),
        .sck_int (sck_int),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    ssp_tx #(.CHAR_BITS(CHAR_BITS)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .sd_out    (sd_o),
        .hold_empty(tx_empty),
        .busy      (tx_busy)
    );

    ssp_rx #(.CHAR_BITS(CHAR_BITS)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .sd_in    (sd_i),
        .rise_ev  (rise_ev),
        .full_clr (rdrf_clr),
        .ovr_clr  (orer_clr),
        .hold_data(rd_data),
        .full     (rx_full),
        .overrun  (rx_overrun)
    );

    // Pin drive: clock pin is an output only in internal mode
    assign sck_o  = sck_int;
    assign sck_oe = ~ext_clk_sel;
endmodule

// File: rtl/ssp_chk.sv
// Property checker for sync_serial_port, attached by bind below.
// Assumes: observes the top-level ports only.
module ssp_chk #(
    parameter int CHAR_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ext_clk_sel,
    input logic                 tx_en,
    input logic                 rx_en,
    input logic                 wr_stb,
    input logic                 rdrf_clr,
    input logic                 orer_clr,
    input logic [CHAR_BITS-1:0] rd_data,
    input logic                 tx_empty,
    input logic                 rx_full,
    input logic                 rx_overrun,
    input logic                 sck_o,
    input logic                 sd_o
);
    // R6
    te_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_en) |-> tx_empty);

    // R5
    empty_fall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_stb && tx_en));

    // R9
    re_off_full_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rx_en && !rdrf_clr) |-> rx_full == $past(rx_full));

    // R9
    re_off_ovr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rx_en && !orer_clr) |-> rx_overrun == $past(rx_overrun));

    // R8
    held_data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_full) |-> $stable(rd_data));

    // R7
    full_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_en));

    // R1
    data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk_sel && $past(!ext_clk_sel) && sd_o != $past(sd_o)) |-> !sck_o);

    // R2
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_en && !rx_en) |-> sck_o);

    // R10
    ext_clock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ext_clk_sel) |-> sck_o);
endmodule

bind sync_serial_port ssp_chk #(.CHAR_BITS(CHAR_BITS)) i_ssp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk_sel(ext_clk_sel),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .wr_stb     (wr_stb),
    .rdrf_clr   (rdrf_clr),
    .orer_clr   (orer_clr),
    .rd_data    (rd_data),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .sck_o      (sck_o),
    .sd_o       (sd_o)
);

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       ext_clk_sel = 1'b0;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rdrf_clr = 1'b0, orer_clr = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, rx_overrun;
    logic       sck_i = 1'b1, sck_o, sck_oe;
    logic       sd_i, sd_o;
    logic       loop_en = 1'b0, drv_sd = 1'b0;

    int nvec = 0, nfail = 0;
    int fall_cnt = 0, rise_cnt = 0;
    int tcnt = 0;

    assign sd_i = loop_en ? sd_o : drv_sd;

    always #5 clk = ~clk;

    sync_serial_port i_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ext_clk_sel(ext_clk_sel),
        .tx_en(tx_en), .rx_en(rx_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .rdrf_clr(rdrf_clr), .orer_clr(orer_clr), .rd_data(rd_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i), .sd_o(sd_o)
    );

    // Rate tick: one pulse every 4 cycles, driven away from the active edge
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        bit_tick = (tcnt == 0);
    end

    // Edge counters on the internal clock pin
    always @(negedge sck_o) fall_cnt++;
    always @(posedge sck_o) rise_cnt++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        wr_stb = 1'b1; wr_data = b;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic clr_full();
        rdrf_clr = 1'b1; @(negedge clk); rdrf_clr = 1'b0;
    endtask

    task automatic wait_rises(input int target, input string req);
        int n = 0;
        while (rise_cnt < target && n < 500) begin @(negedge clk); n++; end
        if (n >= 500) chk(req, "timeout waiting for rising edge", 0, 1);
    endtask

    task automatic wait_falls(input int target, input string req);
        int n = 0;
        while (fall_cnt < target && n < 500) begin @(negedge clk); n++; end
        if (n >= 500) chk(req, "timeout waiting for falling edge", 0, 1);
    endtask

    // Internal clock loopback of one byte with per-bit checks
    task automatic loop_byte(input logic [7:0] b);
        int f0 = fall_cnt;
        int r0 = rise_cnt;
        wr_byte(b);
        for (int i = 0; i < 8; i++) begin
            wait_rises(r0 + i + 1, "R1");
            chk("R1", "bit on line at rising edge", sd_o, b[i]);
        end
        cyc(16);
        chk("R2", "pulses per character", fall_cnt - f0, 8);
        chk("R2", "clock rests high", sck_o, 1);
        chk("R3", "line holds MSB", sd_o, b[7]);
        chk("R5", "tx_empty after send", tx_empty, 1);
        chk("R7", "rx_full after character", rx_full, 1);
        chk("R7", "received byte", rd_data, b);
        cyc(30);
        chk("R7", "rx_full held until clear", rx_full, 1);
        clr_full();
        chk("R7", "rx_full after clear strobe", rx_full, 0);
    endtask

    // External clock loopback of one byte
    task automatic ext_byte(input logic [7:0] b);
        wr_byte(b);
        cyc(6);
        for (int i = 0; i < 8; i++) begin
            sck_i = 1'b0;
            cyc(8);
            chk("R10", "bit on line before external rise", sd_o, b[i]);
            sck_i = 1'b1;
            cyc(8);
        end
        chk("R10", "rx_full after external character", rx_full, 1);
        chk("R10", "received byte external", rd_data, b);
        chk("R10", "sck_o held high", sck_o, 1);
        clr_full();
    endtask

    // Drive one receive-only character bit by bit after counted falls
    task automatic drive_rx(input logic [7:0] b, input int base);
        for (int i = 0; i < 8; i++) begin
            wait_falls(base + i + 1, "R8");
            drv_sd = b[i];
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        int f0, r0, c, first_fall, k;
        logic [7:0] got [2];
        logic sent2;

        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        chk("R5", "reset tx_empty", tx_empty, 1);
        chk("R7", "reset rx_full", rx_full, 0);
        chk("R8", "reset rx_overrun", rx_overrun, 0);
        chk("R2", "reset sck_o", sck_o, 1);
        chk("R2", "reset sck_oe", sck_oe, 1);
        chk("R3", "reset sd_o", sd_o, 1);

        // R5: write with transmit disabled
        f0 = fall_cnt;
        wr_byte(8'h55);
        cyc(40);
        chk("R5", "tx_empty after write with tx_en=0", tx_empty, 1);
        chk("R5", "no pulses with tx_en=0", fall_cnt - f0, 0);

        // R11: both enabled, nothing to send, clock silent
        tx_en = 1'b1; rx_en = 1'b1; loop_en = 1'b1;
        f0 = fall_cnt;
        cyc(60);
        chk("R11", "no pulses without transmit byte", fall_cnt - f0, 0);

        // R1/R2/R3/R7: every byte value through loopback
        for (int v = 0; v < 256; v++) loop_byte(8'(v));

        // R4: back-to-back characters
        f0 = fall_cnt; r0 = rise_cnt; c = 0; first_fall = -1; k = 0; sent2 = 1'b0;
        wr_stb = 1'b1; wr_data = 8'h96;
        while (rise_cnt - r0 < 16 && c < 600) begin
            @(negedge clk);
            c++;
            wr_stb = 1'b0;
            if (!sent2 && c >= 2 && tx_empty) begin
                wr_stb = 1'b1; wr_data = 8'h3A; sent2 = 1'b1;
            end
            if (first_fall < 0 && fall_cnt - f0 >= 1) first_fall = c;
            if (rx_full && !rdrf_clr && k < 2) begin
                got[k] = rd_data; k++; rdrf_clr = 1'b1;
            end else begin
                rdrf_clr = 1'b0;
            end
        end
        @(negedge clk); rdrf_clr = 1'b0;
        cyc(2);
        chk("R4", "first fall to 16th rise cycles", c - first_fall, 124);
        chk("R4", "first received byte", got[0], 8'h96);
        chk("R4", "second received byte", rd_data, 8'h3A);
        chk("R4", "second character completed", rx_full, 1);
        clr_full();

        // R6: abort by dropping tx_en mid-character
        f0 = fall_cnt;
        wr_byte(8'hF0);
        wait_falls(f0 + 3, "R6");
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        chk("R6", "tx_empty forced after tx_en drop", tx_empty, 1);
        cyc(20);
        chk("R9", "clock stops high with both disabled", sck_o, 1);
        tx_en = 1'b1;
        f0 = fall_cnt;
        cyc(60);
        chk("R6", "no residual transfer after re-enable", fall_cnt - f0, 0);
        chk("R6", "tx_empty still set", tx_empty, 1);
        rx_en = 1'b1;
        loop_byte(8'h81);

        // R8/R11/R9: receive-only overrun under the internal clock
        rx_en = 1'b0; tx_en = 1'b0; loop_en = 1'b0; drv_sd = 1'b0;
        cyc(8);
        f0 = fall_cnt;
        rx_en = 1'b1;
        drive_rx(8'hA5, f0);
        drive_rx(8'h3C, f0 + 8);
        cyc(12);
        chk("R8", "rx_full after two characters", rx_full, 1);
        chk("R8", "overrun flagged", rx_overrun, 1);
        chk("R8", "held byte kept on overrun", rd_data, 8'hA5);
        r0 = fall_cnt;
        cyc(40);
        chk("R8", "clock continues after overrun", (fall_cnt - r0) >= 4, 1);
        chk("R11", "receive-only pulses without transmit", (fall_cnt - f0) >= 20, 1);
        rx_en = 1'b0;
        cyc(3);
        r0 = fall_cnt;
        cyc(40);
        chk("R9", "clock stopped after rx_en drop", fall_cnt - r0, 0);
        chk("R9", "clock rests high after rx_en drop", sck_o, 1);
        chk("R9", "rx_full kept", rx_full, 1);
        chk("R9", "rx_overrun kept", rx_overrun, 1);
        chk("R9", "held byte kept", rd_data, 8'hA5);
        orer_clr = 1'b1; @(negedge clk); orer_clr = 1'b0;
        chk("R7", "overrun cleared by its strobe", rx_overrun, 0);
        chk("R7", "rx_full unaffected by overrun clear", rx_full, 1);
        clr_full();
        chk("R7", "rx_full cleared", rx_full, 0);

        // R10: external clock sweep
        ext_clk_sel = 1'b1; loop_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1; sck_i = 1'b1;
        cyc(4);
        chk("R10", "sck_oe in external mode", sck_oe, 0);
        f0 = fall_cnt;
        for (int v = 0; v < 16; v++) ext_byte(8'(v * 37 + 11));
        chk("R10", "no internal pulses in external mode", fall_cnt - f0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule